// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher with Predication

The dispatcher takes a fetch packet of eight 32-bit instructions in one transfer and issues it over one or more cycles. It issues one execute packet per cycle onto eight functional-unit slots. The compiler marks the packet boundaries, so the block does no hazard search of its own. Bit 0 of every instruction is a chain flag. A chain flag of 1 joins the next instruction to the current execute packet. A chain flag of 0 closes the current execute packet. The last instruction of a fetch packet always closes its execute packet, so an execute packet never spans two fetch packets.

Each instruction carries two more fields:
- A unit field that picks the slot the instruction goes to.
- A predicate field that names one of eight condition flags and the test to apply to it.

When the test fails, the slot is issued as a NOP. This lets both arms of an if/else issue in the same cycle with opposite predicates, so no branch is needed. When two instructions of one execute packet target the same unit, the block raises an error flag.

A two-state machine controls the fetch side:
- **IDLE**: no fetch packet is held and `fp_ready` is high. The transition *accept* (IDLE to DRAIN) fires when `fp_valid` is high. It loads the fetch packet and sets the group pointer to instruction 0.
- **DRAIN**: the block issues one execute packet per cycle. The transition *advance* (DRAIN to DRAIN) moves the pointer past the group just issued. The transition *finish* (DRAIN to IDLE) fires when the issued group ends at the last instruction. The next fetch packet is therefore accepted in the cycle after the final execute packet issues.

Top module: `vliw_dispatch`

## Requirements
- R1: An execute packet starts at the current instruction and extends through the first instruction whose bit 0 is 0. All of its instructions appear on their slots in the same cycle, and `iss_pkt` is high in every cycle that issues a packet.
- R2: The last instruction of a fetch packet closes its execute packet whatever its bit 0. A fetch packet whose instructions all have bit 0 set issues as a single eight-wide packet.
- R3: With chain bits 0,1,1,0,1,1,0 on instructions 0 to 6, the block issues instruction 0 alone, then 1–3 together, then 4–6 together, in consecutive cycles.
- R4: Bits [27:25] of an instruction select its slot. A slot with its valid flag set carries the instruction word unchanged.
- R5: Bits [31:29] select a condition flag, and the value 0 means unconditional. Bit 28 = 0 executes the instruction when the flag is 1. Bit 28 = 1 executes it when the flag is 0. A failed test issues the slot as a NOP: the valid flag is 0 and the word is 0.
- R6: If two instructions of one execute packet select the same unit, `unit_clash` is high in that issue cycle. The lower-numbered instruction takes the slot. `unit_clash` is low in every other cycle.
- R7: `fp_ready` is high only in IDLE. A fetch packet is accepted when `fp_valid` and `fp_ready` are both high. While a packet drains, `fp_ready` stays low and `fp_data` has no effect. The next fetch packet can be accepted in the cycle after the last execute packet issues.
- R8: After reset, `fp_ready` is high, and `iss_pkt`, `iss_valid` and `unit_clash` are low.
- R9: Two instructions in one execute packet that test the same flag with opposite senses issue in one cycle, and exactly one of them is valid.
- R10: A fetch packet with k zero chain bits among instructions 0 to 6 issues in exactly k+1 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_valid | input | 1 | A fetch packet is offered |
| fp_ready | output | 1 | The block can accept a fetch packet |
| fp_data | input | 256 | Fetch packet; instruction i is in bits [32i+31:32i] |
| cond_flags | input | 8 | Condition flags; flag n is tested by predicate n (flag 0 is unused) |
| iss_pkt | output | 1 | An execute packet issues this cycle |
| iss_valid | output | 8 | Per-slot valid flag |
| iss_instr | output | 256 | Per-slot instruction word; slot s is in bits [32s+31:32s] |
| unit_clash | output | 1 | Two instructions of the current packet selected the same unit |

## Verification
The bound assertions check the cycle-level rules on every cycle:
- No slot issues while the block is ready.
- An accepted fetch packet leads to an issue cycle on the next cycle.
- Every valid slot carries an instruction whose unit field names that slot.
- Every invalid slot is zeroed.
- A clash is flagged only in an issue cycle.

The directed scenarios show what depends on whole instruction sequences:
- How the chain bits split a fetch packet into cycles.
- The closing of a group at the fetch-packet boundary.
- The predicate decoding against chosen flag values.
- Which instruction wins a clashing slot.
- That data offered during a drain is ignored.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
    localparam int INSTR_W  = 32;
    localparam int CHAIN_B  = 0;
    localparam int UNIT_LO  = 25;
    localparam int UNIT_W   = 3;
    localparam int SENSE_B  = 28;
    localparam int PRED_LO  = 29;
    localparam int PRED_W   = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } disp_state_e;

    function automatic logic [UNIT_W-1:0] unit_of(input logic [INSTR_W-1:0] w);
        return w[UNIT_LO +: UNIT_W];
    endfunction
endpackage

// File: rtl/dsp_group_finder.sv
module dsp_group_finder #(
    parameter int NUM_INSTR = 8,
    localparam int IDXW = $clog2(NUM_INSTR)
) (
    input  logic [IDXW-1:0]      start_idx,
    input  logic [NUM_INSTR-1:0] chain,
    output logic [NUM_INSTR-1:0] in_group,
    output logic [IDXW-1:0]      end_idx,
    output logic                 is_final
);
    logic active;
    logic closed;

    always_comb begin
        active   = 1'b0;
        closed   = 1'b0;
        in_group = '0;
        end_idx  = IDXW'(NUM_INSTR - 1);
        for (int i = 0; i < NUM_INSTR; i++) begin
            if (IDXW'(i) == start_idx && !closed) begin
                active = 1'b1;
            end
            in_group[i] = active;
            if (active && !chain[i]) begin
                end_idx = IDXW'(i);
                active  = 1'b0;
                closed  = 1'b1;
            end
        end
        is_final = (end_idx == IDXW'(NUM_INSTR - 1));
    end
endmodule

// File: rtl/dsp_pred_eval.sv
module dsp_pred_eval
    import vliw_pkg::*;
#(
    parameter int NUM_COND = 8
) (
    input  logic [INSTR_W-1:0]  instr,
    input  logic [NUM_COND-1:0] cond_flags,
    output logic                execute
);
    logic [PRED_W-1:0] sel;
    logic              want_zero;

    assign sel       = instr[PRED_LO +: PRED_W];
    assign want_zero = instr[SENSE_B];

    always_comb begin
        if (sel == '0) begin
            execute = 1'b1;
        end else if (want_zero) begin
            execute = !cond_flags[sel];
        end else begin
            execute = cond_flags[sel];
        end
    end
endmodule

// File: rtl/dsp_slot_xbar.sv
module dsp_slot_xbar
    import vliw_pkg::*;
#(
    parameter int NUM_INSTR = 8,
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_INSTR-1:0][INSTR_W-1:0] instr,
    input  logic [NUM_INSTR-1:0]              in_group,
    input  logic [NUM_INSTR-1:0]              execute,
    output logic [NUM_SLOTS-1:0]              slot_v,
    output logic [NUM_SLOTS-1:0][INSTR_W-1:0] slot_w,
    output logic                              clash
);
    logic [NUM_SLOTS-1:0] taken;

    always_comb begin
        taken  = '0;
        slot_v = '0;
        slot_w = '0;
        clash  = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int i = 0; i < NUM_INSTR; i++) begin
                if (in_group[i] && unit_of(instr[i]) == UNIT_W'(s)) begin
                    if (taken[s]) begin
                        clash = 1'b1;
                    end else begin
                        taken[s]  = 1'b1;
                        slot_v[s] = execute[i];
                        slot_w[s] = execute[i] ? instr[i] : '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
    import vliw_pkg::*;
#(
    parameter int NUM_INSTR = 8,
    parameter int NUM_SLOTS = 8,
    parameter int NUM_COND  = 8,
    localparam int IDXW = $clog2(NUM_INSTR)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fp_valid,
    output logic                           fp_ready,
    input  logic [NUM_INSTR*INSTR_W-1:0]   fp_data,
    input  logic [NUM_COND-1:0]            cond_flags,
    output logic                           iss_pkt,
    output logic [NUM_SLOTS-1:0]           iss_valid,
    output logic [NUM_SLOTS*INSTR_W-1:0]   iss_instr,
    output logic                           unit_clash
);
    disp_state_e state_q, state_d;
    logic [IDXW-1:0] pos_q, pos_d;
    logic [NUM_INSTR-1:0][INSTR_W-1:0] pkt_q, pkt_d;

    logic [NUM_INSTR-1:0]              chain;
    logic [NUM_INSTR-1:0]              in_group;
    logic [NUM_INSTR-1:0]              execute;
    logic [IDXW-1:0]                   end_idx;
    logic                              is_final;
    logic [NUM_SLOTS-1:0]              slot_v;
    logic [NUM_SLOTS-1:0][INSTR_W-1:0] slot_w;
    logic                              clash;

    // Per-instruction chain bit and predicate evaluation
    for (genvar i = 0; i < NUM_INSTR; i++) begin : g_instr
        assign chain[i] = pkt_q[i][CHAIN_B];
        dsp_pred_eval #(.NUM_COND(NUM_COND)) u_pred (
            .instr      (pkt_q[i]),
            .cond_flags (cond_flags),
            .execute    (execute[i])
        );
    end

    dsp_group_finder #(.NUM_INSTR(NUM_INSTR)) u_group (
        .start_idx (pos_q),
        .chain     (chain),
        .in_group  (in_group),
        .end_idx   (end_idx),
        .is_final  (is_final)
    );

    dsp_slot_xbar #(.NUM_INSTR(NUM_INSTR), .NUM_SLOTS(NUM_SLOTS)) u_xbar (
        .instr    (pkt_q),
        .in_group (in_group),
        .execute  (execute),
        .slot_v   (slot_v),
        .slot_w   (slot_w),
        .clash    (clash)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            pkt_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            pkt_q   <= pkt_d;
        end
    end

    // Next-state logic: accept, advance, finish
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        pkt_d   = pkt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fp_valid) begin
                    state_d = ST_DRAIN;
                    pos_d   = '0;
                    pkt_d   = fp_data;
                end
            end
            ST_DRAIN: begin
                if (is_final) begin
                    state_d = ST_IDLE;
                end else begin
                    pos_d = end_idx + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fp_ready   = 1'b0;
        iss_pkt    = 1'b0;
        iss_valid  = '0;
        iss_instr  = '0;
        unit_clash = 1'b0;
        unique case (state_q)
            ST_IDLE: fp_ready = 1'b1;
            ST_DRAIN: begin
                iss_pkt    = 1'b1;
                iss_valid  = slot_v;
                iss_instr  = slot_w;
                unit_clash = clash;
            end
            default: fp_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/vliw_dispatch_chk.sv
module vliw_dispatch_chk
    import vliw_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         fp_valid,
    input logic                         fp_ready,
    input logic                         iss_pkt,
    input logic [NUM_SLOTS-1:0]         iss_valid,
    input logic [NUM_SLOTS*INSTR_W-1:0] iss_instr,
    input logic                         unit_clash
);
    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fp_ready |-> (!iss_pkt && iss_valid == '0 && !unit_clash)); // R7

    AST_ACCEPT_STARTS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready) |=> (iss_pkt && !fp_ready)); // R7

    AST_VALID_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid != '0) |-> iss_pkt); // R1

    AST_CLASH_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_clash |-> iss_pkt); // R6

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        AST_SLOT_MATCHES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> (iss_instr[s*INSTR_W + UNIT_LO +: UNIT_W] == UNIT_W'(s))); // R4

        AST_NOP_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_valid[s] |-> (iss_instr[s*INSTR_W +: INSTR_W] == '0)); // R5
    end
endmodule

bind vliw_dispatch vliw_dispatch_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fp_valid   (fp_valid),
    .fp_ready   (fp_ready),
    .iss_pkt    (iss_pkt),
    .iss_valid  (iss_valid),
    .iss_instr  (iss_instr),
    .unit_clash (unit_clash)
);

// File: tb/vliw_dispatch_test.sv
module vliw_dispatch_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fp_valid = 1'b0;
    logic         fp_ready;
    logic [255:0] fp_data = '0;
    logic [7:0]   cond_flags = '0;
    logic         iss_pkt;
    logic [7:0]   iss_valid;
    logic [255:0] iss_instr;
    logic         unit_clash;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0]   cap_v [16];
    logic [255:0] cap_w [16];
    logic         cap_c [16];
    logic         cap_r [16];

    always #2 clk = ~clk;

    vliw_dispatch uut (
        .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
        .fp_data(fp_data), .cond_flags(cond_flags), .iss_pkt(iss_pkt),
        .iss_valid(iss_valid), .iss_instr(iss_instr), .unit_clash(unit_clash)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit layout: [31:29] predicate, [28] sense, [27:25] unit, [8:1] tag, [0] chain
    function automatic logic [31:0] mk(input logic [2:0] pr, input logic z, input logic [2:0] u,
                                       input logic c, input logic [7:0] tag);
        return {pr, z, u, 16'h0, tag, c};
    endfunction

    task automatic run_fp(input logic [255:0] fp, input bit hold, input logic [255:0] decoy, output int ncyc);
        ncyc = 0;
        @(negedge clk);
        check(fp_ready == 1'b1, "R7 ready before accept", 256'(fp_ready), 256'd1);
        fp_valid = 1'b1;
        fp_data  = fp;
        @(negedge clk);
        fp_valid = hold;
        fp_data  = decoy;
        for (int k = 0; k < 16; k++) begin
            if (!iss_pkt) break;
            cap_v[ncyc] = iss_valid;
            cap_w[ncyc] = iss_instr;
            cap_c[ncyc] = unit_clash;
            cap_r[ncyc] = fp_ready;
            ncyc++;
            @(negedge clk);
        end
        fp_valid = 1'b0;
        check(fp_ready == 1'b1, "R7 ready after last packet", 256'(fp_ready), 256'd1);
    endtask

    task automatic t_reset();
        check(fp_ready == 1'b1, "R8 ready", 256'(fp_ready), 256'd1);
        check(iss_pkt == 1'b0 && iss_valid == 8'h0 && unit_clash == 1'b0, "R8 idle outputs",
              256'({iss_pkt, iss_valid, unit_clash}), 256'd0);
    endtask

    // R3, R1, R10: chain pattern 0,1,1,0,1,1,0 then a closing last instruction
    task automatic t_example(input bit hold);
        logic [31:0] w [8];
        logic [7:0] cb = 8'b0_0_1_1_0_1_1_0; // bit i = chain of instruction i
        logic [255:0] fp = '0;
        logic [255:0] e [4];
        logic [7:0] ev [4];
        int grp [8] = '{0, 1, 1, 1, 2, 2, 2, 3};
        int n;
        for (int i = 0; i < 4; i++) begin e[i] = '0; ev[i] = '0; end
        for (int i = 0; i < 8; i++) begin
            w[i] = mk(3'd0, 1'b0, 3'(i), cb[i], 8'(8'h10 + i));
            fp[i*32 +: 32] = w[i];
            e[grp[i]][i*32 +: 32] = w[i];
            ev[grp[i]][i] = 1'b1;
        end
        run_fp(fp, hold, ~fp, n);
        check(n == 4, "R10 cycles for example", 256'(n), 256'd4);
        for (int c = 0; c < 4; c++) begin
            check(cap_v[c] == ev[c], "R3 valid per cycle", 256'(cap_v[c]), 256'(ev[c]));
            check(cap_w[c] == e[c], "R1 words per cycle", cap_w[c], e[c]);
            if (hold) check(cap_r[c] == 1'b0, "R7 ready low while draining", 256'(cap_r[c]), 256'd0);
        end
        if (hold) begin
            @(negedge clk);
            check(iss_pkt == 1'b0, "R7 decoy not accepted", 256'(iss_pkt), 256'd0);
        end
    endtask

    // R2: all chain bits set gives one eight-wide packet
    task automatic t_full_chain();
        logic [255:0] fp = '0;
        int n;
        for (int i = 0; i < 8; i++) fp[i*32 +: 32] = mk(3'd0, 1'b0, 3'(i), 1'b1, 8'(8'h30 + i));
        run_fp(fp, 1'b0, '0, n);
        check(n == 1, "R2 one packet", 256'(n), 256'd1);
        check(cap_v[0] == 8'hFF, "R2 all slots valid", 256'(cap_v[0]), 256'hFF);
        check(cap_w[0] == fp, "R2 words", cap_w[0], fp);
    endtask

    // R10: all chain bits clear gives eight single packets
    task automatic t_no_chain();
        logic [255:0] fp = '0;
        int n;
        for (int i = 0; i < 8; i++) fp[i*32 +: 32] = mk(3'd0, 1'b0, 3'(7 - i), 1'b0, 8'(8'h50 + i));
        run_fp(fp, 1'b0, '0, n);
        check(n == 8, "R10 eight packets", 256'(n), 256'd8);
        for (int c = 0; c < 8; c++)
            check(cap_v[c] == 8'(1 << (7 - c)), "R4 slot per unit field", 256'(cap_v[c]), 256'(1 << (7 - c)));
    endtask

    // R5: predicate decoding
    task automatic t_predicate();
        logic [2:0] pr [8] = '{3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd7, 3'd7};
        logic       zz [8] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        logic [255:0] fp = '0;
        logic [255:0] e = '0;
        logic [7:0] ev = 8'b0101_0011;
        int n;
        cond_flags = 8'b0000_0010;
        for (int i = 0; i < 8; i++) begin
            fp[i*32 +: 32] = mk(pr[i], zz[i], 3'(i), 1'b1, 8'(8'h70 + i));
            if (ev[i]) e[i*32 +: 32] = fp[i*32 +: 32];
        end
        run_fp(fp, 1'b0, '0, n);
        check(n == 1, "R5 one packet", 256'(n), 256'd1);
        check(cap_v[0] == ev, "R5 executed slots", 256'(cap_v[0]), 256'(ev));
        check(cap_w[0] == e, "R5 NOP slots zero", cap_w[0], e);
        cond_flags = '0;
    endtask

    // R9: if/else arms with opposite senses in one packet
    task automatic t_if_else(input logic [7:0] flags, input logic [7:0] exp_v);
        logic [255:0] fp = '0;
        int n;
        cond_flags = flags;
        fp[0 +: 32]  = mk(3'd4, 1'b0, 3'd2, 1'b1, 8'hA0);
        fp[32 +: 32] = mk(3'd4, 1'b1, 3'd5, 1'b0, 8'hA1);
        for (int i = 2; i < 8; i++) fp[i*32 +: 32] = mk(3'd0, 1'b0, 3'd0, 1'b0, 8'(8'hB0 + i));
        run_fp(fp, 1'b0, '0, n);
        check(n == 7, "R9 cycle count", 256'(n), 256'd7);
        check(cap_v[0] == exp_v, "R9 exactly one arm", 256'(cap_v[0]), 256'(exp_v));
        cond_flags = '0;
    endtask

    // R6: two instructions on unit 3 in one packet
    task automatic t_clash();
        logic [255:0] fp = '0;
        int n;
        fp[0 +: 32]  = mk(3'd0, 1'b0, 3'd3, 1'b1, 8'hC0);
        fp[32 +: 32] = mk(3'd0, 1'b0, 3'd3, 1'b0, 8'hC1);
        for (int i = 2; i < 8; i++) fp[i*32 +: 32] = mk(3'd0, 1'b0, 3'(i), 1'b0, 8'(8'hD0 + i));
        run_fp(fp, 1'b0, '0, n);
        check(n == 7, "R6 cycle count", 256'(n), 256'd7);
        check(cap_c[0] == 1'b1, "R6 clash flagged", 256'(cap_c[0]), 256'd1);
        check(cap_w[0][96 +: 32] == fp[0 +: 32], "R6 lower index wins", 256'(cap_w[0][96 +: 32]), 256'(fp[0 +: 32]));
        for (int c = 1; c < 7; c++)
            check(cap_c[c] == 1'b0, "R6 no clash later", 256'(cap_c[c]), 256'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example(1'b0);
        t_full_chain();
        t_no_chain();
        t_predicate();
        t_if_else(8'h10, 8'h04);
        t_if_else(8'h00, 8'h20);
        t_clash();
        t_example(1'b1);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule